// File: doc/BRIEF.md
# Length-Masked Vector Lane ALU

This block is the element-wise execute step for vector registers. Each register holds a fixed number of signed lanes, eight lanes of 32 bits by default. On a valid strobe it takes two source vectors, the old contents of the destination register, an operation code and a general-purpose register value that supplies the active length. All lanes are computed in parallel. One cycle later it returns the merged destination vector and the updated overflow, underflow and equality flags.

Only lanes below the active length are computed. The remaining lanes are filled with the old destination value, so the tail of the register is left undisturbed. The overflow and underflow flags are the OR of the per-lane conditions over the active lanes only. A compare operation reduces equality over the same lanes. Either source can be marked as the constant register, which reads as 1 in every lane.

Top module: `vlane_alu`

## Requirements
- R1: After reset `outValid`, `result`, `flagOf`, `flagUf` and `flagEq` are all zero.
- R2: `outValid` is high for exactly the cycle after a cycle with `inValid` high. When `inValid` is low, `result` and all three flags hold their values.
- R3: The active length is `lenReg[3:0]`, clamped to LANES (8) when larger; the upper bits of `lenReg` are ignored. Lane i of `result` is computed when i < length and otherwise equals lane i of `destOld`. Lane i occupies bits [32*i+31 : 32*i].
- R4: Opcode 0 adds: lane = A+B, wrapping. `flagOf` is set if any active lane's true sum exceeds the signed maximum. `flagUf` is set if any active lane's true sum is below the signed minimum.
- R5: Opcode 1 subtracts: lane = A-B, wrapping, with `flagOf` and `flagUf` formed as in R4 from the true difference.
- R6: Opcode 2 multiplies: lane = the low 32 bits of A*B. `flagOf` and `flagUf` are set when any active lane's full product lies above the signed maximum or below the signed minimum.
- R7: Opcode 3 divides with truncation toward zero. A zero divisor gives 0x7FFFFFFF in that lane. The minimum value divided by -1 gives 0x80000000. `flagOf` is the OR over every active lane of those two cases, and `flagUf` is cleared.
- R8: Opcode 4 compares: `flagEq` is set exactly when A equals B in every active lane. `flagOf` and `flagUf` are cleared, and `result` equals `destOld` in every lane.
- R9: Opcodes 0 to 3 leave `flagEq` unchanged.
- R10: When `srcAConst` (or `srcBConst`) is high, every lane of that operand reads as 1 and the matching data input is ignored.
- R11: With an active length of 0, no lane changes and `flagOf` and `flagUf` are cleared for opcodes 0 to 4, and opcode 4 sets `flagEq`.
- R12: Opcodes 5 to 7 pulse `outValid` and return `destOld`, leaving all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| opSel | input | 3 | Operation code |
| lenReg | input | WIDTH | General register value holding the active length in its low bits |
| srcA | input | LANES*WIDTH | First source vector |
| srcB | input | LANES*WIDTH | Second source vector |
| srcAConst | input | 1 | First source is the constant-one register |
| srcBConst | input | 1 | Second source is the constant-one register |
| destOld | input | LANES*WIDTH | Prior destination register contents |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| result | output | LANES*WIDTH | Merged destination vector |
| flagOf | output | 1 | Overflow flag |
| flagUf | output | 1 | Underflow flag |
| flagEq | output | 1 | Equality flag |

## Verification
Each operation is applied to vectors with a different value in every lane, so a lane swap or a wrong lane slice shows up in the result. Overflowing, underflowing, zero-divisor and minimum-by-minus-one lanes are placed first inside the active range and then only in the tail. Flags raised by tail lanes therefore separate a correct mask from an unmasked reduction. Lengths of 0, 3, 6, 8, 9, 15 and a value with upper bits set check the clamp and confirm that the high bits are ignored. The sequence of flag values from one operation to the next shows which flags each opcode writes and which it holds.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_DIV = 3'd3,
    OP_CEQ = 3'd4
  } vop_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic writeLanes;
    logic writeArith;
    logic writeEq;
    vop_e op;
  } vctl_t;

endpackage

// File: rtl/vlane_ctrl.sv
module vlane_ctrl
  import vlane_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int LEN_BITS = 4
) (
  input  logic                inValid,
  input  logic [2:0]          opSel,
  input  logic [LEN_BITS-1:0] lenField,
  output vctl_t               ctl,
  output logic [LANES-1:0]    laneMask
);

  int activeLen;

  always_comb begin
    ctl         = '0;
    ctl.op      = vop_e'(opSel);
    ctl.capture = inValid;
    unique case (opSel)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        ctl.writeLanes = inValid;
        ctl.writeArith = inValid;
      end
      3'd4: begin
        ctl.writeArith = inValid;
        ctl.writeEq    = inValid;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (int'(lenField) > LANES) activeLen = LANES;
    else                        activeLen = int'(lenField);
  end

  for (genvar g = 0; g < LANES; g++) begin : gMask
    assign laneMask[g] = (g < activeLen);
  end

endmodule

// File: rtl/vlane_lane.sv
module vlane_lane
  import vlane_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  vop_e             op,
  output logic [WIDTH-1:0] res,
  output logic             ovf,
  output logic             unf,
  output logic             same
);

  localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH:0]     sumW, difW;
  logic [2*WIDTH-1:0] prodW;
  logic [WIDTH-1:0]   safeB, quot;
  logic               divZero, divWrap;
  logic               sumOf, sumUf, difOf, difUf, mulOf, mulUf;

  assign sumW  = {opA[WIDTH-1], opA} + {opB[WIDTH-1], opB};
  assign difW  = {opA[WIDTH-1], opA} - {opB[WIDTH-1], opB};
  assign prodW = {{WIDTH{opA[WIDTH-1]}}, opA} * {{WIDTH{opB[WIDTH-1]}}, opB};

  assign sumOf = !sumW[WIDTH] &&  sumW[WIDTH-1];
  assign sumUf =  sumW[WIDTH] && !sumW[WIDTH-1];
  assign difOf = !difW[WIDTH] &&  difW[WIDTH-1];
  assign difUf =  difW[WIDTH] && !difW[WIDTH-1];
  assign mulOf = !prodW[2*WIDTH-1] &&  (|prodW[2*WIDTH-2:WIDTH-1]);
  assign mulUf =  prodW[2*WIDTH-1] && !(&prodW[2*WIDTH-2:WIDTH-1]);

  assign divZero = (opB == '0);
  assign divWrap = (opA == MINV) && (opB == '1);
  assign safeB   = (divZero || divWrap) ? WIDTH'(1) : opB;
  assign quot    = $signed(opA) / $signed(safeB);

  assign same = (opA == opB);

  always_comb begin
    res = opA;
    ovf = 1'b0;
    unf = 1'b0;
    unique case (op)
      OP_ADD: begin res = sumW[WIDTH-1:0];  ovf = sumOf; unf = sumUf; end
      OP_SUB: begin res = difW[WIDTH-1:0];  ovf = difOf; unf = difUf; end
      OP_MUL: begin res = prodW[WIDTH-1:0]; ovf = mulOf; unf = mulUf; end
      OP_DIV: begin
        res = divZero ? MAXV : (divWrap ? MINV : quot);
        ovf = divZero || divWrap;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/vlane_datapath.sv
module vlane_datapath
  import vlane_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vctl_t                  ctl,
  input  logic [LANES-1:0]       laneMask,
  input  logic [LANES*WIDTH-1:0] srcA,
  input  logic [LANES*WIDTH-1:0] srcB,
  input  logic                   srcAConst,
  input  logic                   srcBConst,
  input  logic [LANES*WIDTH-1:0] destOld,
  output logic                   outValid,
  output logic [LANES*WIDTH-1:0] result,
  output logic                   flagOf,
  output logic                   flagUf,
  output logic                   flagEq
);

  localparam int VW = LANES * WIDTH;

  logic [VW-1:0]    merged;
  logic [LANES-1:0] ovfVec, unfVec, eqVec;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [WIDTH-1:0] opA, opB, laneRes;
    logic             laneOvf, laneUnf, laneSame;

    assign opA = srcAConst ? WIDTH'(1) : srcA[g*WIDTH +: WIDTH];
    assign opB = srcBConst ? WIDTH'(1) : srcB[g*WIDTH +: WIDTH];

    vlane_lane #(.WIDTH(WIDTH)) u_lane (
      .opA  (opA),
      .opB  (opB),
      .op   (ctl.op),
      .res  (laneRes),
      .ovf  (laneOvf),
      .unf  (laneUnf),
      .same (laneSame)
    );

    assign merged[g*WIDTH +: WIDTH] = (ctl.writeLanes && laneMask[g])
                                      ? laneRes : destOld[g*WIDTH +: WIDTH];
    assign ovfVec[g] = laneOvf & laneMask[g];
    assign unfVec[g] = laneUnf & laneMask[g];
    assign eqVec[g]  = laneSame | ~laneMask[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      flagOf   <= 1'b0;
      flagUf   <= 1'b0;
      flagEq   <= 1'b0;
    end else begin
      outValid <= ctl.capture;
      if (ctl.capture) result <= merged;
      if (ctl.writeArith) begin
        flagOf <= |ovfVec;
        flagUf <= |unfVec;
      end
      if (ctl.writeEq) flagEq <= &eqVec;
    end
  end

endmodule

// File: rtl/vlane_alu.sv
module vlane_alu
  import vlane_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int WIDTH    = 32,
  parameter int LEN_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [2:0]             opSel,
  input  logic [WIDTH-1:0]       lenReg,
  input  logic [LANES*WIDTH-1:0] srcA,
  input  logic [LANES*WIDTH-1:0] srcB,
  input  logic                   srcAConst,
  input  logic                   srcBConst,
  input  logic [LANES*WIDTH-1:0] destOld,
  output logic                   outValid,
  output logic [LANES*WIDTH-1:0] result,
  output logic                   flagOf,
  output logic                   flagUf,
  output logic                   flagEq
);

  vctl_t            ctl;
  logic [LANES-1:0] laneMask;
  logic             lenUnused;

  assign lenUnused = ^lenReg[WIDTH-1:LEN_BITS];

  vlane_ctrl #(.LANES(LANES), .LEN_BITS(LEN_BITS)) u_ctrl (
    .inValid  (inValid),
    .opSel    (opSel),
    .lenField (lenReg[LEN_BITS-1:0]),
    .ctl      (ctl),
    .laneMask (laneMask)
  );

  vlane_datapath #(.LANES(LANES), .WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .laneMask  (laneMask),
    .srcA      (srcA),
    .srcB      (srcB),
    .srcAConst (srcAConst),
    .srcBConst (srcBConst),
    .destOld   (destOld),
    .outValid  (outValid),
    .result    (result),
    .flagOf    (flagOf),
    .flagUf    (flagUf),
    .flagEq    (flagEq)
  );

endmodule

// File: rtl/vlane_alu_chk.sv
module vlane_alu_chk #(
  parameter int LANES    = 8,
  parameter int WIDTH    = 32,
  parameter int LEN_BITS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic [2:0]             opSel,
  input logic [LEN_BITS-1:0]    lenLow,
  input logic [LANES*WIDTH-1:0] destOld,
  input logic                   outValid,
  input logic [LANES*WIDTH-1:0] result,
  input logic                   flagOf,
  input logic                   flagUf,
  input logic                   flagEq
);

  int cLen;
  always_comb cLen = (int'(lenLow) > LANES) ? LANES : int'(lenLow);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(flagOf)
                  && $stable(flagUf) && $stable(flagEq)));

  p_div_uf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd3) |=> !flagUf);

  p_cmp_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd4) |=> (!flagOf && !flagUf && result == $past(destOld)));

  p_eq_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel < 3'd4) |=> $stable(flagEq));

  p_zero_len_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lenLow == '0 && opSel <= 3'd4) |=>
      (!flagOf && !flagUf && result == $past(destOld)));

  p_zero_len_eq_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lenLow == '0 && opSel == 3'd4) |=> flagEq);

  p_illegal_r12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel > 3'd4) |=> (result == $past(destOld) && $stable(flagOf)
                                    && $stable(flagUf) && $stable(flagEq)));

  for (genvar g = 0; g < LANES; g++) begin : gTail
    p_tail_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && g >= cLen) |=>
        result[g*WIDTH +: WIDTH] == $past(destOld[g*WIDTH +: WIDTH]));
  end

endmodule

bind vlane_alu vlane_alu_chk #(.LANES(LANES), .WIDTH(WIDTH), .LEN_BITS(LEN_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opSel    (opSel),
  .lenLow   (lenReg[LEN_BITS-1:0]),
  .destOld  (destOld),
  .outValid (outValid),
  .result   (result),
  .flagOf   (flagOf),
  .flagUf   (flagUf),
  .flagEq   (flagEq)
);

// File: tb/vlane_alu_tb.sv
module vlane_alu_tb;

  localparam int LANES = 8;
  localparam int WIDTH = 32;
  localparam int VW    = LANES * WIDTH;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [2:0]    opSel = '0;
  logic [31:0]   lenReg = '0;
  logic [VW-1:0] srcA = '0, srcB = '0, destOld = '0;
  logic          srcAConst = 1'b0, srcBConst = 1'b0;
  logic          outValid;
  logic [VW-1:0] result;
  logic          flagOf, flagUf, flagEq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  expOf = 0, expUf = 0, expEq = 0;

  always #10 clk = ~clk;

  vlane_alu #(.LANES(LANES), .WIDTH(WIDTH), .LEN_BITS(4)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .lenReg(lenReg),
    .srcA(srcA), .srcB(srcB), .srcAConst(srcAConst), .srcBConst(srcBConst),
    .destOld(destOld), .outValid(outValid), .result(result),
    .flagOf(flagOf), .flagUf(flagUf), .flagEq(flagEq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] mk(input longint base, input longint step);
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      longint x = base + i * step;
      v[i*32 +: 32] = x[31:0];
    end
    return v;
  endfunction

  function automatic logic [VW-1:0] put(input logic [VW-1:0] v, input int i,
                                        input longint x);
    logic [VW-1:0] r = v;
    r[i*32 +: 32] = x[31:0];
    return r;
  endfunction

  // apply one operation, model it, and check outputs one cycle later
  task automatic runOp(input string req, input logic [2:0] op, input logic [31:0] len,
                       input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input bit ac, input bit bc, input logic [VW-1:0] d);
    logic [VW-1:0] expR = d;
    bit of = 0, uf = 0, eq = 1;
    int n = (len[3:0] > 4'd8) ? 8 : int'(len[3:0]);
    for (int i = 0; i < n; i++) begin
      longint x = ac ? 64'sd1 : longint'($signed(a[i*32 +: 32]));
      longint y = bc ? 64'sd1 : longint'($signed(b[i*32 +: 32]));
      longint r = 0;
      case (op)
        3'd0: r = x + y;
        3'd1: r = x - y;
        3'd2: r = x * y;
        default: r = 0;
      endcase
      if (op <= 3'd2) begin
        if (r > SMAX) of = 1;
        if (r < SMIN) uf = 1;
        expR[i*32 +: 32] = r[31:0];
      end else if (op == 3'd3) begin
        if (y == 0) begin r = SMAX; of = 1; end
        else if (x == SMIN && y == -1) begin r = SMIN; of = 1; end
        else r = x / y;
        expR[i*32 +: 32] = r[31:0];
      end else if (op == 3'd4) begin
        if (x != y) eq = 0;
      end
    end
    if (op <= 3'd3) begin expOf = of; expUf = uf; end
    else if (op == 3'd4) begin expOf = 0; expUf = 0; expEq = eq; end

    @(negedge clk);
    opSel = op; lenReg = len; srcA = a; srcB = b;
    srcAConst = ac; srcBConst = bc; destOld = d; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, "R2", "outValid", VW'(outValid), VW'(1));
    check(result === expR, req, "result", result, expR);
    check({flagOf, flagUf, flagEq} === {expOf, expUf, expEq}, req, "flags {of,uf,eq}",
          VW'({flagOf, flagUf, flagEq}), VW'({expOf, expUf, expEq}));
  endtask

  task automatic tReset;
    check(outValid === 1'b0 && result === '0, "R1", "outValid/result",
          {result[VW-2:0], outValid}, '0);
    check({flagOf, flagUf, flagEq} === 3'b000, "R1", "flags",
          VW'({flagOf, flagUf, flagEq}), '0);
  endtask

  task automatic tAdd;
    logic [VW-1:0] d = mk(64'h5000, 3);
    runOp("R4", 3'd0, 32'd8, mk(10, 5), mk(-3, 2), 0, 0, d);
    runOp("R4", 3'd0, 32'd4, put(mk(1, 1), 1, SMAX), mk(1, 0), 0, 0, d);
    // overflow only in tail lane 6: flag must stay low
    runOp("R3", 3'd0, 32'd5, put(mk(7, 1), 6, SMAX), mk(1, 0), 0, 0, d);
  endtask

  task automatic tSub;
    runOp("R5", 3'd1, 32'd2, put(mk(-20, 9), 0, SMIN), mk(1, 1), 0, 0, mk(-77, 11));
    runOp("R5", 3'd1, 32'd8, put(mk(40, -3), 4, SMAX), put(mk(2, 2), 4, -1), 0, 0, mk(9, 9));
  endtask

  task automatic tMul;
    logic [VW-1:0] a = put(put(mk(-300, 71), 2, 64'h10000), 3, -64'h10000);
    runOp("R6", 3'd2, 32'd8, a, put(mk(5, -2), 3, 64'h10000), 0, 0, mk(1, 1));
    runOp("R6", 3'd2, 32'd8, put(mk(-300, 71), 5, -64'h10000), put(mk(5, -2), 5, 64'h10000),
          0, 0, mk(1, 1));
  endtask

  task automatic tDiv;
    logic [VW-1:0] a = put(put(mk(100, 7), 2, SMIN), 3, -7);
    logic [VW-1:0] b = put(put(put(mk(3, 1), 1, 0), 2, -1), 3, 2);
    runOp("R7", 3'd3, 32'd8, a, b, 0, 0, mk(0, 1));
    // zero divisor only in the tail
    runOp("R7", 3'd3, 32'd2, mk(-50, 13), put(mk(4, 1), 5, 0), 0, 0, mk(3, 3));
  endtask

  task automatic tCmp;
    logic [VW-1:0] v = mk(4, 4);
    runOp("R7", 3'd3, 32'd8, mk(1, 1), mk(0, 0), 0, 0, mk(0, 0)); // sets OF before compare
    runOp("R8", 3'd4, 32'd8, v, v, 0, 0, mk(99, 1));
    runOp("R8", 3'd4, 32'd8, v, put(v, 2, 1234), 0, 0, mk(99, 1));
    runOp("R3", 3'd4, 32'd6, v, put(v, 6, 1234), 0, 0, mk(99, 1));
  endtask

  task automatic tEqHeld;
    logic [VW-1:0] v = mk(-8, 3);
    runOp("R8", 3'd4, 32'd8, v, v, 0, 0, mk(2, 2));
    runOp("R9", 3'd0, 32'd8, mk(6, 6), mk(1, 2), 0, 0, mk(2, 2));
    runOp("R8", 3'd4, 32'd8, v, put(v, 0, 5), 0, 0, mk(2, 2));
    runOp("R9", 3'd1, 32'd8, mk(6, 6), mk(1, 2), 0, 0, mk(2, 2));
  endtask

  task automatic tLen;
    runOp("R3", 3'd0, 32'h0000_000F, mk(1, 1), mk(100, 100), 0, 0, mk(-1, 0));
    runOp("R3", 3'd0, 32'hABC0_0023, mk(1, 1), mk(100, 100), 0, 0, mk(-1, 0));
    runOp("R3", 3'd1, 32'd9, mk(1, 1), mk(100, 100), 0, 0, mk(-1, 0));
    runOp("R3", 3'd2, 32'd6, mk(3, 1), mk(-2, 1), 0, 0, mk(-1, 0));
  endtask

  task automatic tZero;
    runOp("R4", 3'd0, 32'd8, put(mk(0, 0), 0, SMAX), mk(1, 0), 0, 0, mk(0, 0));
    runOp("R11", 3'd0, 32'h10, put(mk(0, 0), 0, SMAX), mk(1, 0), 0, 0, mk(55, 5));
    runOp("R11", 3'd4, 32'd0, mk(1, 1), mk(2, 2), 0, 0, mk(55, 5));
  endtask

  task automatic tConst;
    runOp("R10", 3'd1, 32'd8, mk(64'h7777, 64'h1111), mk(5, 1), 1, 0, mk(0, 0));
    runOp("R10", 3'd2, 32'd8, mk(-9, 4), mk(64'h1234, 7), 0, 1, mk(0, 0));
  endtask

  task automatic tIllegal;
    runOp("R7", 3'd3, 32'd8, mk(1, 1), mk(0, 0), 0, 0, mk(0, 0)); // OF high
    for (int k = 5; k < 8; k++)
      runOp("R12", 3'(k), 32'd8, mk(1, 1), mk(1, 1), 0, 0, mk(k * 10, 1));
  endtask

  task automatic tHold;
    logic [VW-1:0] keep;
    runOp("R4", 3'd0, 32'd8, put(mk(1, 1), 7, SMAX), mk(1, 0), 0, 0, mk(0, 0));
    keep = result;
    @(negedge clk);
    srcA = mk(42, 42); destOld = mk(17, 1); opSel = 3'd4;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R2", "outValid idle", VW'(outValid), '0);
    check(result === keep, "R2", "result held", result, keep);
    check({flagOf, flagUf, flagEq} === {expOf, expUf, expEq}, "R2", "flags held",
          VW'({flagOf, flagUf, flagEq}), VW'({expOf, expUf, expEq}));
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAdd();
    tSub();
    tMul();
    tDiv();
    tCmp();
    tEqHeld();
    tLen();
    tZero();
    tConst();
    tIllegal();
    tHold();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule